// File: doc/BRIEF.md
# Pseudo-Random QPSK Baseband Symbol Source

This block produces a pseudo-random QPSK baseband test stream for bring-up of a transmit chain. Two 20-stage Fibonacci shift-register generators, one per branch, each give one bit per symbol. The I-branch bit and the Q-branch bit form a bit pair, and the pair selects one of four constellation points. Each coordinate is a signed bipolar value of magnitude one.

The source runs from two rate strobes on one clock. A symbol strobe steps both generators and latches a new constellation point. A sample strobe, expected four times per symbol, moves the stream to the output. The first sample strobe after a symbol carries the point itself. The strobes that follow carry zeros, so the symbol stream is upsampled by zero insertion for a pulse-shaping filter further down the chain.

Top module: `qpsk_pn_symgen`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, both generators load their seed, which is 20'h0003F by default. After release, `out_valid` stays low and both samples read 2'b00, and no symbol value is emitted until the first `sym_en`.
- R2: Each generator is a 20-stage register s[19:0]. On a step its next state is {f, s[19:1]}, where f is the XOR of s[18], s[17], s[14], s[9], s[6], s[5], s[4] and s[0]. Its branch bit is s[0]. A nonzero seed never leads to the all-zero state.
- R3: The generators step exactly once in each cycle where `sym_en` is high, and they hold otherwise.
- R4: On `sym_en`, the bit pair (b0, b1) is formed from the I generator's s[0] as b0 and the Q generator's s[0] as b1, both taken before the step, and the resulting point is latched.
- R5: The point map (b0,b1) to (I,Q) is 00 to (+1,+1), 01 to (-1,+1), 10 to (-1,-1) and 11 to (+1,-1). The 2-bit two's-complement encodings are +1 = 2'b01, -1 = 2'b11 and 0 = 2'b00. The code 2'b10 never appears.
- R6: The first `smp_en` after a `sym_en` emits the latched point. Every later `smp_en` before the next `sym_en` emits 2'b00 on both branches. With the default factor of 4, this gives one symbol sample followed by three zeros.
- R7: When `sym_en` and `smp_en` are high in the same cycle, that sample carries the point captured in that cycle, and it counts as the first of the symbol's strobes.
- R8: `out_valid` is high in the cycle after each cycle with `smp_en` high, and low otherwise. `out_i` and `out_q` change only in those cycles and hold their value between them.
- R9: The Q generator's seed is a separate parameter with the same default. Giving it a different nonzero value makes all four points reachable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_en | input | 1 | Symbol-rate strobe: step generators, latch a new point |
| smp_en | input | 1 | Sample-rate strobe: emit one output sample |
| out_i | output | 2 | I sample, two's complement |
| out_q | output | 2 | Q sample, two's complement |
| out_valid | output | 1 | Sample strobe, one cycle after `smp_en` |

## Verification
The symbol strobe and the sample strobe can coincide. In that cycle the block must capture a new point, step both generators, restart the zero-insertion count and emit a sample. The bench provokes this with the aligned pattern, where both strobes land together on every symbol, and with a random strobe phase where they collide irregularly. In each colliding cycle the emitted sample must be the newly mapped point rather than the stale one, and the next three strobes must be zeros. A reference model steps the same generator recurrence and judges every cycle, on a default-seed instance and on an instance with a different Q seed.

// File: rtl/qpsk_symgen_pkg.sv
package qpsk_symgen_pkg;

    localparam int unsigned PN_W        = 20;
    localparam logic [PN_W-1:0] PN_TAPS = 20'h64271;
    localparam logic [PN_W-1:0] PN_SEED = 20'h0003F;
    localparam int unsigned UPS_DEF     = 4;

    typedef logic [1:0] samp_t;

    localparam samp_t S_POS  = 2'b01;
    localparam samp_t S_NEG  = 2'b11;
    localparam samp_t S_ZERO = 2'b00;

    typedef struct packed {
        samp_t i;
        samp_t q;
    } iq_t;

    typedef enum int unsigned {
        BR_I = 0,
        BR_Q = 1
    } branch_e;

    localparam int unsigned NUM_BR = 2;

    localparam iq_t IQ_ZERO = '{i: S_ZERO, q: S_ZERO};

    function automatic iq_t map_pair(input logic b0, input logic b1);
        iq_t r;
        r.i = (b0 == b1) ? S_POS : S_NEG;
        r.q = b0 ? S_NEG : S_POS;
        return r;
    endfunction

endpackage

// File: rtl/pn_lfsr.sv
module pn_lfsr #(
    parameter int unsigned W          = 20,
    parameter logic [W-1:0] TAPS      = '1,
    parameter logic [W-1:0] SEED      = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic         bit_o,
    output logic [W-1:0] state_o
);

    logic [W-1:0] st;
    logic         fb;

    assign fb = ^(st & TAPS);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= SEED;
        end else if (step) begin
            st <= {fb, st[W-1:1]};
        end
    end

    assign bit_o   = st[0];
    assign state_o = st;

endmodule

// File: rtl/zero_stuffer.sv
module zero_stuffer
    import qpsk_symgen_pkg::*;
#(
    parameter int unsigned UPS = 4,
    localparam int unsigned PH_W = (UPS > 2) ? $clog2(UPS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sym_en,
    input  logic            smp_en,
    input  iq_t             sym_new,
    output iq_t             smp_o,
    output logic            vld_o,
    output logic [PH_W-1:0] phase_o
);

    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(UPS - 1);
    localparam logic [PH_W-1:0] PH_FIRST = '0;
    localparam logic [PH_W-1:0] PH_NEXT  = PH_W'(1);

    iq_t            sym_q;
    iq_t            smp_q;
    logic           vld_q;
    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_q <= IQ_ZERO;
            smp_q <= IQ_ZERO;
            vld_q <= 1'b0;
            phase <= PH_LAST;
        end else begin
            vld_q <= smp_en;
            if (sym_en) begin
                sym_q <= sym_new;
            end
            if (sym_en && smp_en) begin
                smp_q <= sym_new;
                phase <= PH_NEXT;
            end else if (sym_en) begin
                phase <= PH_FIRST;
            end else if (smp_en) begin
                smp_q <= (phase == PH_FIRST) ? sym_q : IQ_ZERO;
                if (phase != PH_LAST) begin
                    phase <= phase + PH_NEXT;
                end
            end
        end
    end

    assign smp_o   = smp_q;
    assign vld_o   = vld_q;
    assign phase_o = phase;

endmodule

// File: rtl/qpsk_pn_symgen.sv
module qpsk_pn_symgen
    import qpsk_symgen_pkg::*;
#(
    parameter int unsigned      LFSR_W = PN_W,
    parameter logic [LFSR_W-1:0] TAPS  = PN_TAPS,
    parameter logic [LFSR_W-1:0] SEED_I = PN_SEED,
    parameter logic [LFSR_W-1:0] SEED_Q = PN_SEED,
    parameter int unsigned      UPS    = UPS_DEF,
    localparam int unsigned     PH_W   = (UPS > 2) ? $clog2(UPS) : 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_en,
    input  logic       smp_en,
    output logic [1:0] out_i,
    output logic [1:0] out_q,
    output logic       out_valid
);

    logic [NUM_BR-1:0] pn_bit;
    logic [LFSR_W-1:0] pn_st [NUM_BR];
    logic [LFSR_W-1:0] pn_st_i;
    logic [LFSR_W-1:0] pn_st_q;
    iq_t               sym_new;
    iq_t               smp;
    logic [PH_W-1:0]   phase;

    for (genvar b = 0; b < NUM_BR; b++) begin : g_br
        localparam logic [LFSR_W-1:0] BR_SEED = (b == int'(BR_I)) ? SEED_I : SEED_Q;
        pn_lfsr #(
            .W    (LFSR_W),
            .TAPS (TAPS),
            .SEED (BR_SEED)
        ) u_pn (
            .clk     (clk),
            .rst     (rst),
            .step    (sym_en),
            .bit_o   (pn_bit[b]),
            .state_o (pn_st[b])
        );
    end

    assign pn_st_i = pn_st[BR_I];
    assign pn_st_q = pn_st[BR_Q];

    assign sym_new = map_pair(pn_bit[BR_I], pn_bit[BR_Q]);

    zero_stuffer #(
        .UPS (UPS)
    ) u_zs (
        .clk     (clk),
        .rst     (rst),
        .sym_en  (sym_en),
        .smp_en  (smp_en),
        .sym_new (sym_new),
        .smp_o   (smp),
        .vld_o   (out_valid),
        .phase_o (phase)
    );

    assign out_i = smp.i;
    assign out_q = smp.q;

endmodule

// File: rtl/qpsk_pn_symgen_chk.sv
module qpsk_pn_symgen_chk #(
    parameter int unsigned      W      = 20,
    parameter logic [W-1:0]     SEED_I = 1,
    parameter logic [W-1:0]     SEED_Q = 1,
    parameter int unsigned      PH_W   = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            sym_en,
    input logic            smp_en,
    input logic [1:0]      out_i,
    input logic [1:0]      out_q,
    input logic            out_valid,
    input logic [W-1:0]    st_i,
    input logic [W-1:0]    st_q,
    input logic [PH_W-1:0] phs
);

    // R1: seeds present right after reset release
    p_reset_seed_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st_i == SEED_I && st_q == SEED_Q));

    // R2: shift direction of the generator
    p_lfsr_shift_r2: assert property (@(posedge clk) disable iff (rst)
        sym_en |=> (st_i[W-2:0] == $past(st_i[W-1:1]) && st_q[W-2:0] == $past(st_q[W-1:1])));

    // R2: lock-up state never reached
    p_lfsr_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
        (st_i != '0) && (st_q != '0));

    // R3: hold without the symbol strobe
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !sym_en |=> ($stable(st_i) && $stable(st_q)));

    // R5: only legal codes appear
    p_code_legal_r5: assert property (@(posedge clk) disable iff (rst)
        (out_i != 2'b10) && (out_q != 2'b10));

    // R6: later strobes of a symbol carry zeros
    p_zero_stuff_r6: assert property (@(posedge clk) disable iff (rst)
        (smp_en && !sym_en && phs != '0) |=> (out_i == 2'b00 && out_q == 2'b00));

    // R7: coincident strobes emit the freshly mapped point
    p_coincide_r7: assert property (@(posedge clk) disable iff (rst)
        (sym_en && smp_en) |=>
            (out_i == (($past(st_i[0]) == $past(st_q[0])) ? 2'b01 : 2'b11) &&
             out_q == ($past(st_i[0]) ? 2'b11 : 2'b01)));

    // R8: valid follows the sample strobe by one cycle
    p_valid_r8: assert property (@(posedge clk) disable iff (rst)
        smp_en |=> out_valid);

    // R8: outputs hold between strobes
    p_hold_out_r8: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> (!out_valid && $stable(out_i) && $stable(out_q)));

endmodule

bind qpsk_pn_symgen qpsk_pn_symgen_chk #(
    .W      (LFSR_W),
    .SEED_I (SEED_I),
    .SEED_Q (SEED_Q),
    .PH_W   (PH_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sym_en    (sym_en),
    .smp_en    (smp_en),
    .out_i     (out_i),
    .out_q     (out_q),
    .out_valid (out_valid),
    .st_i      (pn_st_i),
    .st_q      (pn_st_q),
    .phs       (phase)
);

// File: tb/qpsk_pn_symgen_tb.sv
module qpsk_pn_symgen_tb;

    localparam logic [19:0] SEED     = 20'h0003F;
    localparam logic [19:0] ALT_SEED = 20'h5A5A5;
    localparam int          LAST_PH  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sym_en = 1'b0;
    logic smp_en = 1'b0;

    logic [1:0] oi [2];
    logic [1:0] oq [2];
    logic       ov [2];

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    qpsk_pn_symgen u_dut (
        .clk(clk), .rst(rst), .sym_en(sym_en), .smp_en(smp_en),
        .out_i(oi[0]), .out_q(oq[0]), .out_valid(ov[0])
    );

    // R9: second instance with a distinct Q seed
    qpsk_pn_symgen #(.SEED_Q(ALT_SEED)) u_dut_alt (
        .clk(clk), .rst(rst), .sym_en(sym_en), .smp_en(smp_en),
        .out_i(oi[1]), .out_q(oq[1]), .out_valid(ov[1])
    );

    // reference model state
    logic [19:0] mst [2][2];
    logic [1:0]  msi [2];
    logic [1:0]  msq [2];
    logic [1:0]  moi [2];
    logic [1:0]  moq [2];
    logic        mv;
    int          mph [2];
    bit [3:0]    seen;

    function automatic logic [19:0] tap_mask();
        int pos [8] = '{0, 4, 5, 6, 9, 14, 17, 18};
        logic [19:0] m = '0;
        foreach (pos[n]) m[pos[n]] = 1'b1;
        return m;
    endfunction

    function automatic logic [19:0] nxt(input logic [19:0] s);
        logic f;
        f = ^(s & tap_mask());
        return {f, s[19:1]};
    endfunction

    function automatic logic [1:0] enc(input int v);
        return (v > 0) ? 2'b01 : (v < 0) ? 2'b11 : 2'b00;
    endfunction

    task automatic check(input string tag, input int k);
        vectors++;
        if (oi[k] !== moi[k] || oq[k] !== moq[k] || ov[k] !== mv) begin
            fails++;
            $display("FAIL %s inst%0d t=%0t got i=%b q=%b v=%b exp i=%b q=%b v=%b",
                     tag, k, $time, oi[k], oq[k], ov[k], moi[k], moq[k], mv);
        end
    endtask

    task automatic step(input logic r, input logic s, input logic m);
        string tag;
        @(negedge clk);
        rst = r; sym_en = s; smp_en = m;
        @(posedge clk);
        #1;
        mv = r ? 1'b0 : m;
        for (int k = 0; k < 2; k++) begin
            if (r) begin
                tag = "R1";
                mst[k][0] = SEED;
                mst[k][1] = (k == 0) ? SEED : ALT_SEED;
                msi[k] = 2'b00; msq[k] = 2'b00;
                moi[k] = 2'b00; moq[k] = 2'b00;
                mph[k] = LAST_PH;
            end else begin
                logic b0, b1;
                logic [1:0] ni, nq;
                b0 = mst[k][0][0];
                b1 = mst[k][1][0];
                ni = enc((b0 == b1) ? 1 : -1);   // R5 map
                nq = enc(b0 ? -1 : 1);
                if (s) begin
                    mst[k][0] = nxt(mst[k][0]);  // R2 recurrence, R3 one step
                    mst[k][1] = nxt(mst[k][1]);
                    if (mst[k][0] == '0 || mst[k][1] == '0) begin
                        fails++;
                        $display("FAIL R2 inst%0d model reached zero got=0 exp=nonzero", k);
                    end
                end
                if (s && m) begin
                    tag = "R7";
                    moi[k] = ni; moq[k] = nq; msi[k] = ni; msq[k] = nq; mph[k] = 1;
                end else if (s) begin
                    tag = "R3";
                    msi[k] = ni; msq[k] = nq; mph[k] = 0;
                end else if (m) begin
                    tag = (mph[k] == 0) ? "R4" : "R6";
                    moi[k] = (mph[k] == 0) ? msi[k] : 2'b00;
                    moq[k] = (mph[k] == 0) ? msq[k] : 2'b00;
                    if (mph[k] < LAST_PH) mph[k]++;
                end else begin
                    tag = "R8";
                end
            end
            check(tag, k);
        end
        if (ov[1] && oi[1] != 2'b00) seen[{oi[1][1], oq[1][1]}] = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog got=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        seen = '0;
        // R1: reset state
        for (int c = 0; c < 3; c++) step(1'b1, 1'b0, 1'b0);
        // R1: strobes before any symbol give zeros
        for (int c = 0; c < 6; c++) step(1'b0, 1'b0, c[0]);
        // R7: aligned strobes, 4 samples per symbol
        for (int n = 0; n < 400; n++)
            for (int c = 0; c < 4; c++) step(1'b0, c == 0, 1'b1);
        // R4/R6: symbol strobe one cycle ahead of its samples
        for (int n = 0; n < 300; n++)
            for (int c = 0; c < 6; c++) step(1'b0, c == 0, c >= 1 && c <= 4);
        // R3: advance with no samples, then samples without advance
        for (int c = 0; c < 50; c++) step(1'b0, 1'b1, 1'b0);
        for (int c = 0; c < 8; c++) step(1'b0, 1'b0, 1'b1);
        // R6: surplus strobes per symbol stay zero
        for (int n = 0; n < 100; n++)
            for (int c = 0; c < 8; c++) step(1'b0, c == 0, c >= 1 && c <= 6);
        // R1: reset with a symbol pending
        step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        for (int c = 0; c < 5; c++) step(1'b0, 1'b0, 1'b1);
        // R7 and R8: random strobe phases
        for (int c = 0; c < 3000; c++)
            step(1'b0, ($urandom % 4) == 0, ($urandom % 2) == 0);
        for (int c = 0; c < 200; c++)
            step(1'b0, 1'b1, 1'b1);
        // R9: all four points reached with distinct seeds
        vectors++;
        if (seen != 4'b1111) begin
            fails++;
            $display("FAIL R9 quadrant coverage got=%b exp=1111", seen);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule